// File: doc/BRIEF.md
# GPIO Pad Receive Event Detector

This block is the input side of one general-purpose pad. It brings the raw pad level into the clock domain, can pass it through a short glitch filter or a long power-of-two debounce, can invert it, and turns the result into an event according to a two-bit mode: level, single edge, both edges, or no event. The same block decodes the direction bits of the pad configuration, producing the pad's output enable and output value, and forms the one-bit readback that software sees.

Configuration comes in as two words. Word 0 holds the event mode, the inversion, the filter select, the native-function mode field, the two buffer-disable bits and the transmit and receive state bits. The debounce word holds an enable bit and a four-bit exponent. The debounce time base is a tick of one 31.25 µs unit, made by a clock divider whose length is a parameter.

Top module: `gpio_pad_rx_event`

## Requirements
- R1: While rstN is low, eventOut and readBack (with transmit disabled) are 0 whatever the pad does.
- R2: Event mode code 0 (cfgMain[26:25]) makes eventOut follow the conditioned level; with the invert bit cfgMain[23] set, eventOut is high while the pad is low.
- R3: Event mode code 1 gives a one-cycle eventOut pulse on a rising conditioned level; with cfgMain[23] set the pulse comes on a falling pad instead, and the other direction gives none.
- R4: Event mode code 3 gives a one-cycle eventOut pulse on every pad transition.
- R5: Event mode code 2 never raises eventOut, while the received level seen through readBack still follows the pad.
- R6: With cfgMain[24] clear, a pad change reaches eventOut and readBack 3 cycles later (two synchronizer stages plus one output register).
- R7: With cfgMain[24] set and debounce off (cfgDebounce[0]=0), a level is accepted only after two equal consecutive samples: a one-cycle pad pulse is dropped and a held change arrives 5 cycles later.
- R8: With cfgMain[24] and cfgDebounce[0] both set, the exponent v in cfgDebounce[4:1] makes the filtered level change only after the synchronized input has differed for 2^v ticks; with a tick of T cycles the output moves 2^v*T+3 cycles after the pad, and shorter pulses are dropped.
- R9: An exponent below 3 is raised to 3 (the legal range is 3 to 15).
- R10: cfgDebounce[0] without cfgMain[24] leaves the path unfiltered, with the latency of R6.
- R11: padDriveEn is high exactly when the transmit-disable bit cfgMain[8] is clear and the mode field cfgMain[13:10] is zero; padDriveVal equals cfgMain[0] while driving and is 0 otherwise.
- R12: readBack returns cfgMain[0] when transmit is enabled (cfgMain[8]=0), and otherwise the registered received level, taken before inversion.
- R13: With the receive-disable bit cfgMain[9] set, the received level reads 0 and eventOut stays 0 in every mode, inverted or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| padIn | input | 1 | Raw pad level, asynchronous |
| cfgMain | input | 32 | Pad configuration word 0 |
| cfgDebounce | input | 5 | Bit 0 debounce enable, bits 4:1 exponent |
| padDriveEn | output | 1 | Pad output buffer enable |
| padDriveVal | output | 1 | Value driven on the pad |
| eventOut | output | 1 | Event level or one-cycle event pulse |
| readBack | output | 1 | Transmit state or received level |

## Verification
Each event mode is driven with a rising and a falling pad step, with and without inversion, so that level following, rising-only, falling-only and both-edge pulses are told apart by the cycle after the pulse and by the direction that must stay quiet. The filter paths are driven with a one-cycle spike, a pulse shorter than the debounce window and a held step, at two exponents and one out-of-range exponent, which separates the bypass, glitch-filter and debounce latencies cycle for cycle. Direction settings are walked through GPIO and native modes with both transmit values while the pad is held opposite, so that readback from the transmit bit is distinguished from readback of the pad.

// File: rtl/pad_rx_pkg.sv
package pad_rx_pkg;

  localparam int DEB_MIN_EXP = 3;
  localparam int DEB_MAX_EXP = 15;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evModeT;

  // strobes from control to datapath
  typedef struct packed {
    logic       rxEn;
    logic       useGlitch;
    logic       useDebounce;
    logic [3:0] debExp;
    logic       invert;
    evModeT     evMode;
  } rxCtrlT;

endpackage

// File: rtl/pad_rx_ctrl.sv
module pad_rx_ctrl
  import pad_rx_pkg::*;
(
  input  logic [31:0] cfgMain,
  input  logic [4:0]  cfgDebounce,
  input  logic        rxState,
  output rxCtrlT      ctrl,
  output logic        padDriveEn,
  output logic        padDriveVal,
  output logic        readBack
);

  logic       txEn;
  logic       gpioMode;
  logic       filterSel;
  logic [3:0] rawExp;
  logic       unusedCfg;

  assign txEn      = ~cfgMain[8];
  assign gpioMode  = (cfgMain[13:10] == 4'd0);
  assign filterSel = cfgMain[24];
  assign rawExp    = cfgDebounce[4:1];

  always_comb begin
    ctrl             = '0;
    ctrl.rxEn        = ~cfgMain[9];
    ctrl.useDebounce = filterSel & cfgDebounce[0];
    ctrl.useGlitch   = filterSel & ~cfgDebounce[0];
    ctrl.invert      = cfgMain[23];
    ctrl.evMode      = evModeT'(cfgMain[26:25]);
    if (rawExp < 4'(DEB_MIN_EXP))
      ctrl.debExp = 4'(DEB_MIN_EXP);
    else if (rawExp > 4'(DEB_MAX_EXP))
      ctrl.debExp = 4'(DEB_MAX_EXP);
    else
      ctrl.debExp = rawExp;
  end

  assign padDriveEn  = txEn & gpioMode;
  assign padDriveVal = padDriveEn & cfgMain[0];
  assign readBack    = txEn ? cfgMain[0] : rxState;

  assign unusedCfg = ^{cfgMain[31:27], cfgMain[22:14], cfgMain[7:1]};

endmodule

// File: rtl/pad_rx_debounce.sv
module pad_rx_debounce
  import pad_rx_pkg::*;
#(
  parameter int TICK_CYCLES = 1563
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleIn,
  input  logic [3:0] debExp,
  output logic       level
);

  localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int CNT_W  = DEB_MAX_EXP + 1;

  logic [TICK_W-1:0] tickCnt;
  logic [CNT_W-1:0]  unitCnt;
  logic [CNT_W-1:0]  target;
  logic              tick;
  logic              lastUnit;

  assign tick     = (tickCnt == TICK_W'(TICK_CYCLES - 1));
  assign target   = CNT_W'(1) << debExp;
  assign lastUnit = (unitCnt == target - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      unitCnt <= '0;
      level   <= 1'b0;
    end else if (sampleIn == level) begin
      tickCnt <= '0;
      unitCnt <= '0;
    end else if (tick) begin
      tickCnt <= '0;
      if (lastUnit) begin
        level   <= sampleIn;
        unitCnt <= '0;
      end else begin
        unitCnt <= unitCnt + CNT_W'(1);
      end
    end else begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

endmodule

// File: rtl/pad_rx_datapath.sv
module pad_rx_datapath
  import pad_rx_pkg::*;
#(
  parameter int TICK_CYCLES  = 1563,
  parameter int SYNC_STAGES  = 2,
  parameter bit HAS_DEBOUNCE = 1'b1
)(
  input  logic   clk,
  input  logic   rstN,
  input  logic   padIn,
  input  rxCtrlT ctrl,
  output logic   eventOut,
  output logic   rxState
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncOut;
  logic glitchPrev;
  logic glitchLevel;
  logic debLevel;
  logic filtered;
  logic rxLevel;
  logic cond;
  logic condPrev;
  logic eventNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // two equal consecutive samples are needed to move the glitch level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glitchPrev  <= 1'b0;
      glitchLevel <= 1'b0;
    end else begin
      glitchPrev <= syncOut;
      if (syncOut == glitchPrev) glitchLevel <= syncOut;
    end
  end

  generate
    if (HAS_DEBOUNCE) begin : g_deb
      pad_rx_debounce #(.TICK_CYCLES(TICK_CYCLES)) u_deb (
        .clk     (clk),
        .rstN    (rstN),
        .sampleIn(syncOut),
        .debExp  (ctrl.debExp),
        .level   (debLevel)
      );
    end else begin : g_nodeb
      assign debLevel = syncOut;
    end
  endgenerate

  always_comb begin
    if (ctrl.useDebounce)    filtered = debLevel;
    else if (ctrl.useGlitch) filtered = glitchLevel;
    else                     filtered = syncOut;
  end

  assign rxLevel = ctrl.rxEn & filtered;
  assign cond    = ctrl.rxEn & (filtered ^ ctrl.invert);

  always_comb begin
    unique case (ctrl.evMode)
      EV_LEVEL: eventNext = cond;
      EV_EDGE:  eventNext = cond & ~condPrev;
      EV_BOTH:  eventNext = cond ^ condPrev;
      default:  eventNext = 1'b0;
    endcase
    eventNext = eventNext & ctrl.rxEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev <= 1'b0;
      eventOut <= 1'b0;
      rxState  <= 1'b0;
    end else begin
      condPrev <= cond;
      eventOut <= eventNext;
      rxState  <= rxLevel;
    end
  end

endmodule

// File: rtl/gpio_pad_rx_event.sv
module gpio_pad_rx_event
  import pad_rx_pkg::*;
#(
  parameter int TICK_CYCLES = 1563,
  parameter int SYNC_STAGES = 2
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        padIn,
  input  logic [31:0] cfgMain,
  input  logic [4:0]  cfgDebounce,
  output logic        padDriveEn,
  output logic        padDriveVal,
  output logic        eventOut,
  output logic        readBack
);

  rxCtrlT ctrl;
  logic   rxState;

  pad_rx_ctrl u_ctrl (
    .cfgMain    (cfgMain),
    .cfgDebounce(cfgDebounce),
    .rxState    (rxState),
    .ctrl       (ctrl),
    .padDriveEn (padDriveEn),
    .padDriveVal(padDriveVal),
    .readBack   (readBack)
  );

  pad_rx_datapath #(
    .TICK_CYCLES (TICK_CYCLES),
    .SYNC_STAGES (SYNC_STAGES),
    .HAS_DEBOUNCE(1'b1)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .padIn   (padIn),
    .ctrl    (ctrl),
    .eventOut(eventOut),
    .rxState (rxState)
  );

endmodule

// File: rtl/pad_rx_event_checker.sv
module pad_rx_event_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] evMode,
  input logic       rxOff,
  input logic       txOff,
  input logic       txBit,
  input logic       eventOut,
  input logic       padDriveEn,
  input logic       padDriveVal,
  input logic       readBack
);

  // R3: single-edge mode never gives two event cycles in a row
  a_r3_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (evMode == 2'd1 && $stable(evMode) && eventOut) |=> !eventOut);

  // R5: mode code 2 gives no event
  a_r5_off_mode_silent: assert property (@(posedge clk) disable iff (!rstN)
    ($past(evMode) == 2'd2) |-> !eventOut);

  // R13: receive buffer off gives no event
  a_r13_rx_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxOff) |-> !eventOut);

  // R11: nothing driven high while the buffer is off
  a_r11_quiet_when_not_driving: assert property (@(posedge clk) disable iff (!rstN)
    !padDriveEn |-> !padDriveVal);

  // R12: transmit enabled, readback shows the transmit bit
  a_r12_readback_tx: assert property (@(posedge clk) disable iff (!rstN)
    !txOff |-> (readBack == txBit));

endmodule

bind gpio_pad_rx_event pad_rx_event_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evMode     (cfgMain[26:25]),
  .rxOff      (cfgMain[9]),
  .txOff      (cfgMain[8]),
  .txBit      (cfgMain[0]),
  .eventOut   (eventOut),
  .padDriveEn (padDriveEn),
  .padDriveVal(padDriveVal),
  .readBack   (readBack)
);

// File: tb/test_gpio_pad_rx_event.sv
module test_gpio_pad_rx_event;

  localparam int TICK = 2;
  localparam int SEL_EV = 0, SEL_RB = 1, SEL_DEN = 2, SEL_DVAL = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        padIn = 1'b0;
  logic [31:0] cfgMain = '0;
  logic [4:0]  cfgDebounce = '0;
  logic        padDriveEn, padDriveVal, eventOut, readBack;

  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    sel;
    bit    val;
    string tag;
  } itemT;
  itemT sbq[$];

  gpio_pad_rx_event #(.TICK_CYCLES(TICK)) i_gpio_pad_rx_event (
    .clk(clk), .rstN(rstN), .padIn(padIn), .cfgMain(cfgMain),
    .cfgDebounce(cfgDebounce), .padDriveEn(padDriveEn),
    .padDriveVal(padDriveVal), .eventOut(eventOut), .readBack(readBack)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit pick(int sel);
    case (sel)
      SEL_EV:  return eventOut;
      SEL_RB:  return readBack;
      SEL_DEN: return padDriveEn;
      default: return padDriveVal;
    endcase
  endfunction

  // monitor: pop and compare items that are due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      itemT it;
      bit act;
      it = sbq.pop_front();
      act = pick(it.sel);
      nChecks++;
      if (act !== it.val) begin
        nErr++;
        $display("FAIL %s: output %0d at cycle %0d actual %0b expected %0b",
                 it.tag, it.sel, cyc, act, it.val);
      end
    end
  end

  task automatic expectAt(int d, int sel, bit v, string tag);
    itemT it;
    it.at = cyc + d; it.sel = sel; it.val = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setCfg(logic [1:0] mode, bit inv, bit filt, bit debEn,
                        logic [3:0] ex, bit txDis, bit rxDis, bit txBit,
                        logic [3:0] pmode);
    drain();
    cfgMain = '0;
    cfgMain[26:25] = mode;
    cfgMain[24] = filt;
    cfgMain[23] = inv;
    cfgMain[13:10] = pmode;
    cfgMain[9] = rxDis;
    cfgMain[8] = txDis;
    cfgMain[0] = txBit;
    cfgDebounce = {ex, debEn};
    waitN(80);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R1: reset holds outputs low with pad high in level mode
    cfgMain[8] = 1'b1;
    padIn = 1'b1;
    waitN(2);
    expectAt(1, SEL_EV, 1'b0, "R1");
    expectAt(2, SEL_RB, 1'b0, "R1");
    waitN(4);
    padIn = 1'b0;
    waitN(2);
    rstN = 1'b1;
    waitN(10);

    // R2 / R6: level mode, plain path
    setCfg(2'd0, 0, 0, 0, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(2, SEL_EV, 1'b0, "R6");
    expectAt(3, SEL_EV, 1'b1, "R2");
    expectAt(3, SEL_RB, 1'b1, "R12");
    drain();
    padIn = 1'b0;
    expectAt(2, SEL_EV, 1'b1, "R6");
    expectAt(3, SEL_EV, 1'b0, "R2");
    drain();

    // R2: active-low level
    setCfg(2'd0, 1, 0, 0, 4'd3, 1, 0, 0, 4'd0);
    expectAt(1, SEL_EV, 1'b1, "R2");
    drain();
    padIn = 1'b1;
    expectAt(3, SEL_EV, 1'b0, "R2");
    expectAt(3, SEL_RB, 1'b1, "R12");
    drain();
    padIn = 1'b0;
    expectAt(3, SEL_EV, 1'b1, "R2");
    drain();

    // R3: rising edge
    setCfg(2'd1, 0, 0, 0, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(2, SEL_EV, 1'b0, "R3");
    expectAt(3, SEL_EV, 1'b1, "R3");
    expectAt(4, SEL_EV, 1'b0, "R3");
    drain();
    padIn = 1'b0;
    expectAt(3, SEL_EV, 1'b0, "R3");
    expectAt(4, SEL_EV, 1'b0, "R3");
    drain();

    // R3: falling edge via inversion
    setCfg(2'd1, 1, 0, 0, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(3, SEL_EV, 1'b0, "R3");
    expectAt(4, SEL_EV, 1'b0, "R3");
    drain();
    padIn = 1'b0;
    expectAt(3, SEL_EV, 1'b1, "R3");
    expectAt(4, SEL_EV, 1'b0, "R3");
    drain();

    // R4: both edges
    setCfg(2'd3, 0, 0, 0, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(3, SEL_EV, 1'b1, "R4");
    expectAt(4, SEL_EV, 1'b0, "R4");
    drain();
    padIn = 1'b0;
    expectAt(3, SEL_EV, 1'b1, "R4");
    expectAt(4, SEL_EV, 1'b0, "R4");
    drain();

    // R5: event off, received level still tracked
    setCfg(2'd2, 0, 0, 0, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(3, SEL_EV, 1'b0, "R5");
    expectAt(3, SEL_RB, 1'b1, "R5");
    drain();
    padIn = 1'b0;
    expectAt(3, SEL_EV, 1'b0, "R5");
    expectAt(3, SEL_RB, 1'b0, "R5");
    drain();

    // R7: glitch filter drops a one-cycle spike, passes a held step
    setCfg(2'd0, 0, 1, 0, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(3, SEL_EV, 1'b0, "R7");
    expectAt(5, SEL_EV, 1'b0, "R7");
    expectAt(7, SEL_EV, 1'b0, "R7");
    waitN(1);
    padIn = 1'b0;
    drain();
    padIn = 1'b1;
    expectAt(4, SEL_EV, 1'b0, "R7");
    expectAt(5, SEL_EV, 1'b1, "R7");
    drain();
    padIn = 1'b0;
    expectAt(4, SEL_EV, 1'b1, "R7");
    expectAt(5, SEL_EV, 1'b0, "R7");
    drain();

    // R8: debounce exponent 3, 8 ticks of 2 cycles
    setCfg(2'd0, 0, 1, 1, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(18, SEL_EV, 1'b0, "R8");
    expectAt(19, SEL_EV, 1'b1, "R8");
    drain();
    padIn = 1'b0;
    expectAt(18, SEL_EV, 1'b1, "R8");
    expectAt(19, SEL_EV, 1'b0, "R8");
    drain();
    padIn = 1'b1;
    expectAt(12, SEL_EV, 1'b0, "R8");
    expectAt(19, SEL_EV, 1'b0, "R8");
    expectAt(25, SEL_EV, 1'b0, "R8");
    waitN(10);
    padIn = 1'b0;
    drain();

    // R9: exponent 0 behaves as 3
    setCfg(2'd0, 0, 1, 1, 4'd0, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(18, SEL_EV, 1'b0, "R9");
    expectAt(19, SEL_EV, 1'b1, "R9");
    drain();
    padIn = 1'b0;

    // R8: exponent 4, 16 ticks
    setCfg(2'd0, 0, 1, 1, 4'd4, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(34, SEL_EV, 1'b0, "R8");
    expectAt(35, SEL_EV, 1'b1, "R8");
    drain();
    padIn = 1'b0;

    // R10: debounce enable without the filter select
    setCfg(2'd0, 0, 0, 1, 4'd3, 1, 0, 0, 4'd0);
    padIn = 1'b1;
    expectAt(2, SEL_EV, 1'b0, "R10");
    expectAt(3, SEL_EV, 1'b1, "R10");
    drain();
    padIn = 1'b0;

    // R11 / R12: transmit enabled in GPIO mode, pad held opposite
    setCfg(2'd0, 0, 0, 0, 4'd3, 0, 0, 1, 4'd0);
    expectAt(1, SEL_DEN, 1'b1, "R11");
    expectAt(1, SEL_DVAL, 1'b1, "R11");
    expectAt(1, SEL_RB, 1'b1, "R12");
    drain();
    padIn = 1'b1;
    setCfg(2'd0, 0, 0, 0, 4'd3, 0, 0, 0, 4'd0);
    expectAt(1, SEL_DVAL, 1'b0, "R11");
    expectAt(1, SEL_RB, 1'b0, "R12");
    drain();
    padIn = 1'b0;
    setCfg(2'd0, 0, 0, 0, 4'd3, 0, 0, 1, 4'd3);
    expectAt(1, SEL_DEN, 1'b0, "R11");
    expectAt(1, SEL_DVAL, 1'b0, "R11");
    expectAt(1, SEL_RB, 1'b1, "R12");
    drain();
    setCfg(2'd0, 0, 0, 0, 4'd3, 1, 0, 1, 4'd0);
    expectAt(1, SEL_DEN, 1'b0, "R11");
    expectAt(1, SEL_RB, 1'b0, "R12");
    drain();

    // R13: receive buffer disabled
    setCfg(2'd0, 0, 0, 0, 4'd3, 1, 1, 0, 4'd0);
    padIn = 1'b1;
    expectAt(3, SEL_EV, 1'b0, "R13");
    expectAt(3, SEL_RB, 1'b0, "R13");
    drain();
    padIn = 1'b0;
    setCfg(2'd0, 1, 0, 0, 4'd3, 1, 1, 0, 4'd0);
    expectAt(1, SEL_EV, 1'b0, "R13");
    drain();

    done = 1'b1;
    finishRun();
  end

endmodule